// File: doc/BRIEF.md
# Three-Channel Interval Timer Register Front End

This block is the byte-wide register front end of a three-channel, 16-bit programmable interval timer. It also holds the three down counters behind that interface. A host reaches four registers: counter 0, counter 1 and counter 2 at register indices 0, 1 and 2, and a command register at index 3. The byte address of a register is its index shifted left by the parameter `ADDR_SHIFT`, and the address bits below that shift are ignored.

Writes to the command register do one of three things: program a counter, freeze a counter's value for reading, or request a read-back of status and/or count for several counters at once. A 16-bit count moves through a counter address as two bytes, low byte first and high byte second. Each counter decrements once per clock in which `cnt_en` is high. It runs in one of three waveform modes: one-shot terminal count, rate pulse, or square wave. The block keeps one sticky flag, `cfg_err`, which records an illegal count load.

Top module: `pit3_bus_front`

## Requirements
- R1: The register index is `bus_addr[ADDR_SHIFT+1:ADDR_SHIFT]`. Indices 0 to 2 select counters 0 to 2 and index 3 selects the command register. `rdata` reads 0x00 whenever index 3 is addressed.
- R2: A command byte whose bits 7:6 are not 11 and whose bits 5:4 are nonzero programs the counter named by bits 7:6. Bits 5:0 are stored as the counter's setup: bits 3:1 hold the mode and bit 0 is a flag that is only stored. Programming does four things: it returns the write and read byte pointers to the low byte, drops any pending latch or status, halts the counter and sets the null-count flag.
- R3: Two successive writes to a counter address load the count, low byte then high byte. The count takes effect on the second write, which also clears null-count. Reads from the same address return the low byte and then the high byte.
- R4: A loaded count of 0 behaves as 65536. It reads back as 0x0000, and after one tick it reads 0xFFFF.
- R5: A command byte with bits 5:4 equal to 00 (and bits 7:6 not 11) freezes the selected counter's value until one low/high read pair completes. The counter keeps running. A second freeze before that pair completes is ignored.
- R6: A command byte with bits 7:6 equal to 11 is a read-back. Bit 1, bit 2 and bit 3 select counters 0, 1 and 2. Bit 5 clear freezes the count and bit 4 clear captures status. The status byte is {output level, null-count, setup bits 5:0}. A pending status is returned by the next read, before any count bytes.
- R7: Mode 0: programming drives the output low, and loading the count keeps it low. The output goes high on the tick that takes the count from 1 to 0. The count then holds at 0 with the output high.
- R8: Mode 2: the output is high except while the count equals 1. The tick after that reloads the full count.
- R9: Mode 3: the output is high while the count is above floor(N/2) and low otherwise. The count reloads after reaching 1, so a count of 4 gives two ticks high and two ticks low.
- R10: Loading a count of 1 in mode 2 or mode 3 sets `cfg_err`. The flag stays set until reset. A count of 1 in mode 0 does not set it.
- R11: In modes 1, 4, 5, 6 and 7 the counter does not move and the output stays high.
- R12: If a freeze coincides with a tick, the frozen value is the count from before that tick. If a count load coincides with a tick, the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_SHIFT+2 | Byte address; the register index sits above the shift |
| bus_wr | input | 1 | Write strobe, one clock per byte |
| bus_rd | input | 1 | Read strobe, one clock per byte; advances read pointers |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data for the addressed register (combinational) |
| cnt_en | input | 1 | Count tick enable, one decrement per high clock |
| tmr_out | output | 3 | Output level of each counter |
| cfg_err | output | 1 | Sticky illegal-count flag |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a freeze command and a count tick. The bench holds `cnt_en` high across the freeze write and expects the read pair to return the count from before that edge, not the decremented value. The second pair is a count load and a tick. The bench writes the high byte with `cnt_en` high and expects the fresh count, unreduced, on the next read. A read-back command that asks for both status and count in one write is also judged by the read order: the status byte comes first, then the frozen low and high bytes.

// File: rtl/pit_pkg.sv
// Shared constants for the three-channel timer front end.
// Assumes 8-bit bus bytes and 16-bit counts moved as two bytes.
package pit_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 16;
    localparam int NUM_CH = 3;
    localparam int CFG_W  = 6;
    localparam int IDX_W  = 2;

    typedef enum logic [2:0] {
        MODE_TERM = 3'd0,
        MODE_ONE  = 3'd1,
        MODE_RATE = 3'd2,
        MODE_SQW  = 3'd3
    } pit_mode_e;
endpackage

// File: rtl/pit_cmd_dec.sv
// Command and strobe decoder. It turns a bus access into per-channel
// strobes: program, freeze count, capture status, data write, data read.
// Assumes at most one of bus_wr / bus_rd is high in a cycle.
module pit_cmd_dec
    import pit_pkg::*;
(
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:1]        cmd_bits,
    output logic [NUM_CH-1:0] prog_wr,
    output logic [NUM_CH-1:0] latch_req,
    output logic [NUM_CH-1:0] status_req,
    output logic [NUM_CH-1:0] data_wr,
    output logic [NUM_CH-1:0] data_rd
);
    localparam logic [IDX_W-1:0] CMD_IDX = IDX_W'(NUM_CH);

    logic is_cmd;
    logic is_rb;
    logic acc_zero;

    // Classify the command byte written to the command index.
    always_comb begin
        is_cmd   = bus_wr && (reg_idx == CMD_IDX);
        is_rb    = (cmd_bits[7:6] == 2'b11);
        acc_zero = (cmd_bits[5:4] == 2'b00);
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [IDX_W-1:0] CH_IDX = IDX_W'(ch);
        logic named;
        logic rb_sel;
        // Per-channel selection by the counter field or a read-back bit.
        always_comb begin
            named          = !is_rb && (cmd_bits[7:6] == CH_IDX);
            rb_sel         = is_rb && cmd_bits[ch+1];
            prog_wr[ch]    = is_cmd && named && !acc_zero;
            latch_req[ch]  = is_cmd && ((named && acc_zero) || (rb_sel && !cmd_bits[5]));
            status_req[ch] = is_cmd && rb_sel && !cmd_bits[4];
            data_wr[ch]    = bus_wr && (reg_idx == CH_IDX);
            data_rd[ch]    = bus_rd && (reg_idx == CH_IDX);
        end
    end
endmodule

// File: rtl/pit_chan.sv
// One timer channel: setup store, byte pointers, freeze and status
// holding registers, and a down counter in mode 0, 2 or 3.
// Assumes the strobes come from pit_cmd_dec and are mutually exclusive.
module pit_chan
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              prog_wr,
    input  logic [CFG_W-1:0]  prog_val,
    input  logic              latch_req,
    input  logic              status_req,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              out_pin,
    output logic              bad_load
);
    localparam int EXT_W = CNT_W + 1;
    localparam logic [EXT_W-1:0] FULL_CNT = EXT_W'(1) << CNT_W;
    localparam logic [EXT_W-1:0] ONE_CNT  = EXT_W'(1);

    logic [CFG_W-1:0]  cfg_q;
    logic [EXT_W-1:0]  cnt_q, rld_q;
    logic [BYTE_W-1:0] lo_q, sts_val_q;
    logic [CNT_W-1:0]  lat_val_q;
    logic wr_hi_q, rd_hi_q, null_q, armed_q, m0_out_q, lat_q, sts_q;

    pit_mode_e         mode;
    logic [CNT_W-1:0]  load_val;
    logic [EXT_W-1:0]  load_ext;
    logic [CNT_W-1:0]  rd_src;
    logic              load_now, runs;

    // Decode the current mode and the value a completing load would take.
    always_comb begin
        mode     = pit_mode_e'(cfg_q[3:1]);
        load_val = {wdata, lo_q};
        load_ext = (load_val == '0) ? FULL_CNT : {1'b0, load_val};
        load_now = data_wr && wr_hi_q;
        runs     = armed_q && (mode == MODE_TERM || mode == MODE_RATE || mode == MODE_SQW);
        bad_load = load_now && (load_val == CNT_W'(1)) && (mode == MODE_RATE || mode == MODE_SQW);
    end

    // Output level per mode.
    always_comb begin
        case (mode)
            MODE_TERM: out_pin = m0_out_q;
            MODE_RATE: out_pin = !(armed_q && cnt_q == ONE_CNT);
            MODE_SQW:  out_pin = !armed_q || (cnt_q > (rld_q >> 1));
            default:   out_pin = 1'b1;
        endcase
    end

    // Setup register and write byte pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            wr_hi_q <= 1'b0;
            lo_q    <= '0;
            null_q  <= 1'b0;
        end else if (prog_wr) begin
            cfg_q   <= prog_val;
            wr_hi_q <= 1'b0;
            null_q  <= 1'b1;
        end else if (data_wr) begin
            if (!wr_hi_q) begin
                lo_q    <= wdata;
                wr_hi_q <= 1'b1;
            end else begin
                wr_hi_q <= 1'b0;
                null_q  <= 1'b0;
            end
        end
    end

    // Down counter, reload value and the mode 0 output latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            rld_q    <= '0;
            armed_q  <= 1'b0;
            m0_out_q <= 1'b1;
        end else if (prog_wr) begin
            armed_q  <= 1'b0;
            m0_out_q <= 1'b0;
        end else if (load_now) begin
            cnt_q    <= load_ext;
            rld_q    <= load_ext;
            armed_q  <= 1'b1;
            m0_out_q <= 1'b0;
        end else if (tick && runs) begin
            if (mode == MODE_TERM) begin
                if (cnt_q != '0) cnt_q <= cnt_q - ONE_CNT;
                if (cnt_q == ONE_CNT) m0_out_q <= 1'b1;
            end else begin
                cnt_q <= (cnt_q == ONE_CNT) ? rld_q : cnt_q - ONE_CNT;
            end
        end
    end

    // Freeze, status capture and read byte pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_hi_q   <= 1'b0;
            lat_q     <= 1'b0;
            sts_q     <= 1'b0;
            lat_val_q <= '0;
            sts_val_q <= '0;
        end else if (prog_wr) begin
            rd_hi_q <= 1'b0;
            lat_q   <= 1'b0;
            sts_q   <= 1'b0;
        end else begin
            if (latch_req && !lat_q) begin
                lat_q     <= 1'b1;
                lat_val_q <= cnt_q[CNT_W-1:0];
            end
            if (status_req && !sts_q) begin
                sts_q     <= 1'b1;
                sts_val_q <= {out_pin, null_q, cfg_q};
            end
            if (data_rd) begin
                if (sts_q) begin
                    sts_q <= 1'b0;
                end else if (rd_hi_q) begin
                    rd_hi_q <= 1'b0;
                    lat_q   <= 1'b0;
                end else begin
                    rd_hi_q <= 1'b1;
                end
            end
        end
    end

    // Read byte: pending status first, then frozen or live count bytes.
    always_comb begin
        rd_src  = lat_q ? lat_val_q : cnt_q[CNT_W-1:0];
        rd_byte = sts_q ? sts_val_q : (rd_hi_q ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0]);
    end
endmodule

// File: rtl/pit3_bus_front.sv
// Top of the three-channel timer front end: address slicing, command
// decode, three channels and the sticky illegal-count flag.
// Assumes single-cycle byte strobes and no simultaneous read and write.
module pit3_bus_front
    import pit_pkg::*;
#(
    parameter int ADDR_SHIFT = 1,
    localparam int ADDR_W = ADDR_SHIFT + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              cnt_en,
    output logic [2:0]        tmr_out,
    output logic              cfg_err
);
    logic [IDX_W-1:0]  reg_idx;
    logic [NUM_CH-1:0] prog_wr, latch_req, status_req, data_wr, data_rd, bad_load;
    logic [BYTE_W-1:0] chan_rd [NUM_CH];
    logic              unused_addr_bits;

    assign reg_idx          = bus_addr[ADDR_W-1:ADDR_SHIFT];
    assign unused_addr_bits = ^bus_addr;

    pit_cmd_dec u_dec (
        .reg_idx    (reg_idx),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .cmd_bits   (wdata[7:1]),
        .prog_wr    (prog_wr),
        .latch_req  (latch_req),
        .status_req (status_req),
        .data_wr    (data_wr),
        .data_rd    (data_rd)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        pit_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (cnt_en),
            .prog_wr    (prog_wr[ch]),
            .prog_val   (wdata[CFG_W-1:0]),
            .latch_req  (latch_req[ch]),
            .status_req (status_req[ch]),
            .data_wr    (data_wr[ch]),
            .data_rd    (data_rd[ch]),
            .wdata      (wdata),
            .rd_byte    (chan_rd[ch]),
            .out_pin    (tmr_out[ch]),
            .bad_load   (bad_load[ch])
        );
    end

    // Read mux: addressed channel byte, zero for the command index.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_idx == IDX_W'(i)) rdata = chan_rd[i];
        end
    end

    // Sticky flag for an illegal count load.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= cfg_err | (|bad_load);
    end
endmodule

// File: rtl/pit3_bus_front_chk.sv
// Property checker for pit3_bus_front, attached through bind.
// Observes only top-level ports.
module pit3_bus_front_chk #(
    parameter int ADDR_SHIFT = 1,
    localparam int ADDR_W = ADDR_SHIFT + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic              cnt_en,
    input logic [2:0]        tmr_out,
    input logic              cfg_err
);
    logic [1:0] idx;
    logic       unused_chk_bits;
    assign idx             = bus_addr[ADDR_W-1:ADDR_SHIFT];
    assign unused_chk_bits = ^{bus_addr, wdata[0]};

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R7
    term_prog_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == 2'd3 && wdata[7:6] == 2'b00 && wdata[5:4] != 2'b00 && wdata[3:1] == 3'd0)
        |=> !tmr_out[0]);

    // R8
    rate_prog_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == 2'd3 && wdata[7:6] == 2'b00 && wdata[5:4] != 2'b00 && wdata[3:1] == 3'd2)
        |=> tmr_out[0]);

    // R1
    cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && idx == 2'd3) |-> (rdata == 8'h00));

    // R11
    out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !bus_wr) |=> $stable(tmr_out));
endmodule

bind pit3_bus_front pit3_bus_front_chk #(.ADDR_SHIFT(ADDR_SHIFT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .wdata    (wdata),
    .rdata    (rdata),
    .cnt_en   (cnt_en),
    .tmr_out  (tmr_out),
    .cfg_err  (cfg_err)
);

// File: tb/test_pit3_bus_front.sv
`timescale 1ns/100ps
// Scoreboard bench: read tasks queue expected bytes, a monitor compares them.
module test_pit3_bus_front;
    localparam int SH = 1;
    localparam logic [2:0] A_C0 = 3'd0, A_C1 = 3'd2, A_C2 = 3'd4, A_CMD = 3'd6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, cnt_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] tmr_out;
    logic cfg_err;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    typedef struct { logic [7:0] val; string tag; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    pit3_bus_front #(.ADDR_SHIFT(SH)) i_pit3_bus_front (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en),
        .tmr_out(tmr_out), .cfg_err(cfg_err)
    );

    // Monitor: compare each read byte against the queued expectation.
    always @(negedge clk) begin
        if (bus_rd) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: actual=%02h expected=none", rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rdata !== e.val) begin
                    errors++;
                    $display("FAIL %s: actual=%02h expected=%02h", e.tag, rdata, e.val);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        it.val = e; it.tag = tag;
        exp_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        cnt_en = 1'b1;
        repeat (n) begin @(posedge clk); #1; end
        cnt_en = 1'b0;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("reset tmr_out", tmr_out, 3'b111);
        chk("reset cfg_err", cfg_err, 0);

        // R1: command index reads as zero
        rd(A_CMD, 8'h00, "R1 cmd read");

        // R3 / R8: mode 2, count 5
        wr(A_CMD, 8'h34); wr(A_C0, 8'h05); wr(A_C0, 8'h00);
        rd(A_C0, 8'h05, "R3 low"); rd(A_C0, 8'h00, "R3 high");
        tick(3);
        rd(A_C0, 8'h02, "R3 low after ticks"); rd(A_C0, 8'h00, "R3 high after ticks");
        chk("R8 high at 2", tmr_out[0], 1);
        tick(1); chk("R8 low at 1", tmr_out[0], 0);
        tick(1); chk("R8 reload high", tmr_out[0], 1);
        chk("R10 no err legal", cfg_err, 0);

        // R4: zero means 65536
        wr(A_CMD, 8'h70); wr(A_C1, 8'h00); wr(A_C1, 8'h00);
        rd(A_C1, 8'h00, "R4 low"); rd(A_C1, 8'h00, "R4 high");
        tick(1);
        rd(A_C1, 8'hFF, "R4 low wrap"); rd(A_C1, 8'hFF, "R4 high wrap");

        // R7: mode 0 terminal count
        wr(A_CMD, 8'h70); chk("R7 low on prog", tmr_out[1], 0);
        wr(A_C1, 8'h03); wr(A_C1, 8'h00);
        tick(2); chk("R7 low at 1", tmr_out[1], 0);
        tick(1); chk("R7 high at 0", tmr_out[1], 1);
        tick(2); chk("R7 stays high", tmr_out[1], 1);
        rd(A_C1, 8'h00, "R7 holds 0"); rd(A_C1, 8'h00, "R7 holds 0 hi");

        // R9: mode 3 square wave, N=4
        wr(A_CMD, 8'hB6); wr(A_C2, 8'h04); wr(A_C2, 8'h00);
        chk("R9 4 high", tmr_out[2], 1);
        tick(1); chk("R9 3 high", tmr_out[2], 1);
        tick(1); chk("R9 2 low", tmr_out[2], 0);
        tick(1); chk("R9 1 low", tmr_out[2], 0);
        tick(1); chk("R9 reload high", tmr_out[2], 1);

        // R10: illegal count sticky
        wr(A_CMD, 8'h70); wr(A_C1, 8'h01); wr(A_C1, 8'h00);
        chk("R10 mode0 count1 legal", cfg_err, 0);
        wr(A_CMD, 8'hB6); wr(A_C2, 8'h01); wr(A_C2, 8'h00);
        chk("R10 set", cfg_err, 1);
        wr(A_CMD, 8'hB0); wr(A_C2, 8'h05); wr(A_C2, 8'h00);
        chk("R10 sticky", cfg_err, 1);

        // R11: mode 1 does not count
        wr(A_CMD, 8'h72); wr(A_C1, 8'h03); wr(A_C1, 8'h00);
        tick(2);
        chk("R11 out high", tmr_out[1], 1);
        rd(A_C1, 8'h03, "R11 frozen low"); rd(A_C1, 8'h00, "R11 frozen high");

        // R2: programming resets byte pointers
        wr(A_CMD, 8'h34); wr(A_C0, 8'h55);
        wr(A_CMD, 8'h34); wr(A_C0, 8'h07); wr(A_C0, 8'h00);
        rd(A_C0, 8'h07, "R2 write ptr reset");
        wr(A_CMD, 8'h34);
        rd(A_C0, 8'h07, "R2 read ptr reset"); rd(A_C0, 8'h00, "R2 high");

        // R5 / R12: freeze coinciding with a tick
        wr(A_CMD, 8'h34); wr(A_C0, 8'h10); wr(A_C0, 8'h00);
        cnt_en = 1'b1; wr(A_CMD, 8'h00);
        tick(3);
        wr(A_CMD, 8'h00);
        rd(A_C0, 8'h10, "R12 freeze pre-tick"); rd(A_C0, 8'h00, "R5 frozen high");
        rd(A_C0, 8'h0C, "R5 live low"); rd(A_C0, 8'h00, "R5 live high");

        // R12: load coinciding with a tick
        cnt_en = 1'b1; wr(A_C0, 8'h20); wr(A_C0, 8'h00); cnt_en = 1'b0;
        rd(A_C0, 8'h20, "R12 load wins"); rd(A_C0, 8'h00, "R12 load high");

        // R6: read-back of status and count for counter 0
        wr(A_CMD, 8'hC2);
        rd(A_C0, 8'hB4, "R6 status ch0"); rd(A_C0, 8'h20, "R6 count low");
        rd(A_C0, 8'h00, "R6 count high");

        // R6: status only, counter 2 with null count and stored flag bit
        wr(A_CMD, 8'hB1);
        wr(A_CMD, 8'hE8);
        rd(A_C2, 8'h71, "R6 status ch2");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule